// File: doc/BRIEF.md
# Table-Driven Byte Stream Pattern Matcher

This block scans a byte stream for a set of fixed patterns by running a deterministic state machine that is held entirely in a lookup table. On each accepted character it concatenates the current state with the character to form a table address. It reads back a stored word that gives the next state and a per-pattern match vector. Table contents are compiled offline and written in through a simple write port before traffic starts.

Only transitions that lead to a non-root state need to be stored. Every table entry has its own programmed flag. An entry that was never written sends the machine back to the root state and reports no match. The match vector is registered and shows up one cycle after the character that completed a pattern, together with a single-cycle strobe.

Top module: `pattern_dfa`

## Requirements
- R1: After reset, the state is 0, `match_o` is 0, `match_stb_o` is low, and every table entry is unprogrammed.
- R2: The table address is the current state in the upper bits and the 8-bit character in the lower bits. An entry written for state S and character C is used only when the machine is in state S and receives C.
- R3: When a valid character hits a programmed entry, the state becomes that entry's next state, and `match_o` shows that entry's match vector one clock after the character is accepted.
- R4: When a valid character hits an unprogrammed entry, the state returns to 0 and `match_o` is 0 on the following cycle.
- R5: `match_stb_o` is high exactly when the previous cycle accepted a character whose match vector is nonzero. After a cycle with no valid character, `match_o` is 0.
- R6: Cycles without a valid character leave the state unchanged, so idle gaps inside a pattern do not break a match.
- R7: With the patterns "bcdf" (vector 8'h01, final state 4) and "pcdg" (vector 8'h02, final state 8) loaded, the stream "bcdfpcdg" reports 8'h01 after the 4th character and 8'h02 after the 8th, and 0 after every other character.
- R8: From state 7, the character 'g' moves the machine to state 8 and reports match vector 8'h02.
- R9: Writing an entry again replaces both its next state and its match vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_valid_i | input | 1 | Character on `char_i` is accepted this cycle |
| char_i | input | 8 | Input character |
| wr_en_i | input | 1 | Write one table entry |
| wr_state_i | input | STATE_W | State part of the write address |
| wr_char_i | input | 8 | Character part of the write address |
| wr_next_i | input | STATE_W | Next state to store |
| wr_match_i | input | PAT_W | Match vector to store |
| match_o | output | PAT_W | Registered match vector, zero if no pattern ended |
| match_stb_o | output | 1 | High for one cycle when `match_o` is nonzero |

## Verification
The assertions assume that the table is not written while characters are streaming. A write to the entry being read would make the stored word and the read word differ by one cycle. The bench loads the whole table before streaming begins. It makes its later rewrites only when `char_valid_i` is low. It also assumes that stored next-state values stay inside the table. The bench writes only states 0 to 8 and 15, and all of them fit in the default state width.

// File: rtl/pattern_dfa_pkg.sv
package pattern_dfa_pkg;
  localparam int unsigned CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/pattern_dfa_addr.sv
module pattern_dfa_addr
  import pattern_dfa_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  localparam int unsigned ADDR_W = STATE_W + CHAR_W
) (
  input  logic [STATE_W-1:0] state_i,
  input  char_t              char_i,
  output logic [ADDR_W-1:0]  addr_o
);
  // state in the upper field, character in the lower field
  assign addr_o = {state_i, char_i};
endmodule

// File: rtl/pattern_dfa_table.sv
module pattern_dfa_table #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PAT_W   = 8,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned WORD_W = STATE_W + PAT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [STATE_W-1:0] wr_next_i,
  input  logic [PAT_W-1:0]   wr_match_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               rd_hit_o,
  output logic [STATE_W-1:0] rd_next_o,
  output logic [PAT_W-1:0]   rd_match_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  prog_q;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= '0;
    else if (wr_en_i) prog_q[wr_addr_i] <= 1'b1;
  end

  // payload needs no reset: gated by prog_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= {wr_next_i, wr_match_i};
  end

  assign rd_hit_o = prog_q[rd_addr_i];
  assign word     = rd_hit_o ? mem_q[rd_addr_i] : '0;
  assign {rd_next_o, rd_match_o} = word;
endmodule

// File: rtl/pattern_dfa_core.sv
module pattern_dfa_core #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PAT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [STATE_W-1:0] next_i,
  input  logic [PAT_W-1:0]   vec_i,
  output logic [STATE_W-1:0] state_o,
  output logic [PAT_W-1:0]   match_o,
  output logic               match_stb_o
);
  logic [STATE_W-1:0] state_q;
  logic [PAT_W-1:0]   match_q;
  logic               stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      match_q <= '0;
      stb_q   <= 1'b0;
    end else begin
      if (step_i) state_q <= next_i;
      match_q <= step_i ? vec_i : '0;
      stb_q   <= step_i && (vec_i != '0);
    end
  end

  assign state_o     = state_q;
  assign match_o     = match_q;
  assign match_stb_o = stb_q;
endmodule

// File: rtl/pattern_dfa.sv
module pattern_dfa
  import pattern_dfa_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PAT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               char_valid_i,
  input  logic [7:0]         char_i,
  input  logic               wr_en_i,
  input  logic [STATE_W-1:0] wr_state_i,
  input  logic [7:0]         wr_char_i,
  input  logic [STATE_W-1:0] wr_next_i,
  input  logic [PAT_W-1:0]   wr_match_i,
  output logic [PAT_W-1:0]   match_o,
  output logic               match_stb_o
);
  localparam int unsigned ADDR_W = STATE_W + CHAR_W;

  logic [STATE_W-1:0] state_q;
  logic [ADDR_W-1:0]  rd_addr, wr_addr;
  logic               rd_hit;
  logic [STATE_W-1:0] rd_next;
  logic [PAT_W-1:0]   rd_match;

  pattern_dfa_addr #(.STATE_W(STATE_W)) u_rd_addr (
    .state_i(state_q), .char_i(char_i), .addr_o(rd_addr)
  );

  pattern_dfa_addr #(.STATE_W(STATE_W)) u_wr_addr (
    .state_i(wr_state_i), .char_i(wr_char_i), .addr_o(wr_addr)
  );

  pattern_dfa_table #(.ADDR_W(ADDR_W), .STATE_W(STATE_W), .PAT_W(PAT_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr),
    .wr_next_i(wr_next_i), .wr_match_i(wr_match_i),
    .rd_addr_i(rd_addr), .rd_hit_o(rd_hit),
    .rd_next_o(rd_next), .rd_match_o(rd_match)
  );

  pattern_dfa_core #(.STATE_W(STATE_W), .PAT_W(PAT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(char_valid_i),
    .next_i(rd_next), .vec_i(rd_match),
    .state_o(state_q), .match_o(match_o), .match_stb_o(match_stb_o)
  );
endmodule

// File: rtl/pattern_dfa_chk.sv
module pattern_dfa_chk #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned PAT_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               char_valid_i,
  input logic               rd_hit,
  input logic [STATE_W-1:0] rd_next,
  input logic [STATE_W-1:0] state_q,
  input logic [PAT_W-1:0]   match_o,
  input logic               match_stb_o
);
  assert_next_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && rd_hit) |=> (state_q == $past(rd_next)));

  assert_unprog_root_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !rd_hit) |=> (state_q == '0 && match_o == '0));

  assert_stb_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_stb_o |-> (match_o != '0));

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_valid_i |=> (match_o == '0 && !match_stb_o));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_valid_i |=> $stable(state_q));
endmodule

bind pattern_dfa pattern_dfa_chk #(.STATE_W(STATE_W), .PAT_W(PAT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .char_valid_i(char_valid_i),
  .rd_hit(rd_hit), .rd_next(rd_next), .state_q(state_q),
  .match_o(match_o), .match_stb_o(match_stb_o)
);

// File: tb/pattern_dfa_test.sv
module pattern_dfa_test;
  localparam int STATE_W = 4;
  localparam int PAT_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_valid = 1'b0;
  logic [7:0] chr = '0;
  logic wr_en = 1'b0;
  logic [STATE_W-1:0] wr_state = '0;
  logic [7:0] wr_char = '0;
  logic [STATE_W-1:0] wr_next = '0;
  logic [PAT_W-1:0] wr_match = '0;
  logic [PAT_W-1:0] match;
  logic match_stb;

  int n_vec = 0;
  int n_bad = 0;
  int m_state = 0;

  always #4 clk = ~clk;

  pattern_dfa #(.STATE_W(STATE_W), .PAT_W(PAT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(char_valid), .char_i(chr),
    .wr_en_i(wr_en), .wr_state_i(wr_state), .wr_char_i(wr_char),
    .wr_next_i(wr_next), .wr_match_i(wr_match),
    .match_o(match), .match_stb_o(match_stb)
  );

  // reference: pattern 0 "bcdf" -> states 1..4, pattern 1 "pcdg" -> states 5..8
  function automatic byte pat_ch(int p, int k);
    string s;
    s = (p == 0) ? "bcdf" : "pcdg";
    return s[k];
  endfunction

  function automatic int ref_next(int s, byte c);
    int p, d;
    if (s >= 1 && s <= 8) begin
      p = (s - 1) / 4;
      d = (s - 1) % 4 + 1;
      if (d < 4 && c == pat_ch(p, d)) return s + 1;
    end else if (s == 0) begin
      if (c == pat_ch(0, 0)) return 1;
      if (c == pat_ch(1, 0)) return 5;
      return 0;
    end
    if (c == pat_ch(0, 0)) return 1;
    if (c == pat_ch(1, 0)) return 5;
    return 0;
  endfunction

  function automatic int ref_vec(int s);
    return (s == 4) ? 1 : (s == 8) ? 2 : 0;
  endfunction

  task automatic check(int exp_vec, string req);
    logic exp_stb;
    exp_stb = (exp_vec != 0);
    n_vec++;
    if (match !== exp_vec[PAT_W-1:0] || match_stb !== exp_stb) begin
      n_bad++;
      $display("FAIL %s: match=%h stb=%b expected match=%h stb=%b",
               req, match, match_stb, exp_vec[PAT_W-1:0], exp_stb);
    end
  endtask

  // drive one cycle; output checked one clock later
  task automatic step(logic v, byte c, int exp_vec, string req);
    char_valid = v;
    chr = c;
    @(negedge clk);
    char_valid = 1'b0;
    check(exp_vec, req);
  endtask

  // model-tracked step for the two-pattern table
  task automatic mstep(byte c, string req);
    m_state = ref_next(m_state, c);
    step(1'b1, c, ref_vec(m_state), req);
  endtask

  task automatic wr(int s, int c, int nxt, int vec);
    wr_en = 1'b1;
    wr_state = s[STATE_W-1:0];
    wr_char = c[7:0];
    wr_next = nxt[STATE_W-1:0];
    wr_match = vec[PAT_W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    string s;
    logic [15:0] lfsr;
    byte alpha [7];
    alpha = '{"b", "c", "d", "f", "g", "p", "x"};

    repeat (3) @(negedge clk);
    check(0, "R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    check(0, "R1 after release");
    step(1'b1, "b", 0, "R1 table empty after reset");
    step(1'b1, "c", 0, "R1 table empty after reset");

    // reset again so the state is 0, then load the DFA
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int st = 0; st <= 8; st++)
      for (int c = 0; c < 256; c++) begin
        int n;
        n = ref_next(st, byte'(c));
        if (n != 0) wr(st, c, n, ref_vec(n));
      end
    m_state = 0;

    s = "bcdfpcdg";
    for (int i = 0; i < s.len(); i++) mstep(s[i], "R7 overlap stream");

    mstep("b", "R6 gap");
    mstep("c", "R6 gap");
    step(1'b0, "z", 0, "R5 idle quiet");
    step(1'b0, "f", 0, "R6 idle ignores char");
    mstep("d", "R6 gap");
    mstep("f", "R6 gap completes");

    s = "bcdxf";
    for (int i = 0; i < s.len(); i++) mstep(s[i], "R4 unprogrammed to root");

    mstep("p", "R8");
    mstep("c", "R8");
    mstep("d", "R8");
    step(1'b1, "g", 2, "R8 state 7 on g");
    m_state = 8;

    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mstep(alpha[lfsr % 7], "R3 sweep");
    end

    // rewrite (3,'f') with a new vector
    wr(3, "f", 4, 8'h80);
    s = "bcdf";
    for (int i = 0; i < 3; i++) mstep(s[i], "R9 prefix");
    step(1'b1, "f", 8'h80, "R9 rewritten entry");
    m_state = 4;
    mstep("x", "R9 back to root");

    // address field split: state 15 / char 8'hFF
    wr(0, 8'hA5, 15, 0);
    wr(15, 8'hFF, 0, 8'h40);
    step(1'b1, 8'hFF, 0, "R2 char FF in state 0 unmapped");
    step(1'b1, 8'hA5, 0, "R2 enter state 15");
    step(1'b1, 8'hFF, 8'h40, "R2 state 15 char FF");
    step(1'b1, 8'hFF, 0, "R2 back in state 0");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule